// File: doc/BRIEF.md
# Branch Condition and Target Resolver

This purely combinational unit sits beside the execute stage of a 32-bit processor. Each cycle it receives the current program counter, one source register value, a 21-bit immediate and a 4-bit control-transfer opcode. From these it decides whether control flow changes and produces the next program counter. For jump-and-link it also supplies the return address and a write enable for the link register.

Conditional branches test a single register against two references: zero, or the all-ones pattern. Some tests are signed comparisons with zero. Branch offsets count words, so the immediate is sign-extended and multiplied by four. Register jumps add the same scaled offset to the source register, and a caller that wants a PC-relative jump presents the PC on the source input.

A separate data path always produces the PC plus the immediate shifted left by eleven bits. Pairing that result with a jump or a memory access gives full 32-bit PC-relative reach in two instructions. Fetch, pipeline flushing and register-file writes belong to the surrounding pipeline.

Top module: `branch_resolve_unit`

## Requirements
- R1: Opcode encoding on `op_i`: 0 jump, 1 jump-and-link, 2 branch-if-zero, 3 branch-if-nonzero, 4 branch-if-all-ones, 5 branch-if-not-all-ones, 6 branch-if-negative, 7 branch-if-non-negative, 8 branch-if-non-positive, 9 branch-if-positive, 10 PC-high-add. A taken conditional branch gives `next_pc_o` = pc + sign_extend(imm)*4, modulo 2^32.
- R2: Opcodes 0 and 1 always assert `taken_o` and give `next_pc_o` = src + sign_extend(imm)*4, modulo 2^32.
- R3: `link_we_o` is 1 for opcode 1 and 0 for every other opcode. While it is 1, `link_value_o` equals pc+4.
- R4: Opcode 2 is taken exactly when src equals 0. Opcode 3 is taken exactly when src does not equal 0.
- R5: Opcode 4 is taken exactly when src equals 0xFFFFFFFF. Opcode 5 is taken exactly when src does not equal 0xFFFFFFFF.
- R6: Opcode 6 is taken exactly when src, read as signed, is below zero. Opcode 7 is taken exactly when src is at or above zero.
- R7: Opcode 8 is taken exactly when signed src is at or below zero. Opcode 9 is taken exactly when signed src is above zero.
- R8: Whenever `taken_o` is 0, `next_pc_o` equals pc+4, modulo 2^32.
- R9: `pchi_result_o` always equals pc + (imm << 11), modulo 2^32. Opcode 10 gives `taken_o`=0 and `link_we_o`=0.
- R10: Opcodes 11 to 15 are unrecognized. They give `taken_o`=0, `link_we_o`=0 and `next_pc_o`=pc+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Current program counter |
| src_i | input | 32 | Source register value (tested or jump base) |
| imm_i | input | 21 | Immediate field |
| op_i | input | 4 | Control-transfer opcode |
| taken_o | output | 1 | Control flow leaves the sequential path |
| next_pc_o | output | 32 | Address of the next instruction |
| link_we_o | output | 1 | Write enable for the link register |
| link_value_o | output | 32 | Return address pc+4 |
| pchi_result_o | output | 32 | pc + (imm << 11) data result |

## Verification
The hardest cases sit at the boundaries of the signed tests and the address arithmetic. The most negative and most positive values, minus one, zero and one must each land on the correct side of all eight conditions. Adds must also wrap past 2^32 when the offset is negative or the PC sits near the top of the address space. The stimulus sweeps a fixed set of edge source values through every conditional opcode. Separately, it pairs PCs near 0 and near 0xFFFFFFFC with immediates whose sign bit is set or clear, so every adder sees both carry-out and borrow.

// File: rtl/bru_pkg.sv
package bru_pkg;
  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_JMP    = 4'd0,
    OP_JMPL   = 4'd1,
    OP_BEQZ   = 4'd2,
    OP_BNEZ   = 4'd3,
    OP_BONES  = 4'd4,
    OP_BNONES = 4'd5,
    OP_BNEG   = 4'd6,
    OP_BNNEG  = 4'd7,
    OP_BNPOS  = 4'd8,
    OP_BPOS   = 4'd9,
    OP_PCHI   = 4'd10
  } bru_op_e;

  typedef struct packed {
    logic is_jump;
    logic is_link;
    logic is_cond;
    logic is_pchi;
  } bru_class_t;
endpackage

// File: rtl/bru_decode.sv
module bru_decode
  import bru_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output bru_class_t      cls
);
  always_comb begin
    cls = '0;
    case (op)
      OP_JMP:  cls.is_jump = 1'b1;
      OP_JMPL: begin
        cls.is_jump = 1'b1;
        cls.is_link = 1'b1;
      end
      OP_BEQZ, OP_BNEZ, OP_BONES, OP_BNONES,
      OP_BNEG, OP_BNNEG, OP_BNPOS, OP_BPOS: cls.is_cond = 1'b1;
      OP_PCHI: cls.is_pchi = 1'b1;
      default: cls = '0;
    endcase
  end
endmodule

// File: rtl/bru_cond_eval.sv
module bru_cond_eval
  import bru_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] src,
  input  logic [OP_W-1:0] op,
  output logic            cond_true
);
  logic zero_q;
  logic ones_q;
  logic neg_q;

  always_comb begin
    zero_q = ~|src;
    ones_q = &src;
    neg_q  = src[XLEN-1];
  end

  always_comb begin
    case (op)
      OP_BEQZ:   cond_true = zero_q;
      OP_BNEZ:   cond_true = ~zero_q;
      OP_BONES:  cond_true = ones_q;
      OP_BNONES: cond_true = ~ones_q;
      OP_BNEG:   cond_true = neg_q;
      OP_BNNEG:  cond_true = ~neg_q;
      OP_BNPOS:  cond_true = neg_q | zero_q;
      OP_BPOS:   cond_true = ~neg_q & ~zero_q;
      default:   cond_true = 1'b0;
    endcase
  end
endmodule

// File: rtl/bru_target_gen.sv
module bru_target_gen #(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned IMM_W    = 21,
  parameter int unsigned WORD_SH  = 2,
  parameter int unsigned HI_SH    = 11
) (
  input  logic [XLEN-1:0]  pc,
  input  logic [XLEN-1:0]  src,
  input  logic [IMM_W-1:0] imm,
  output logic [XLEN-1:0]  br_target,
  output logic [XLEN-1:0]  jmp_target,
  output logic [XLEN-1:0]  seq_pc,
  output logic [XLEN-1:0]  hi_sum
);
  localparam int unsigned HI_W   = IMM_W + HI_SH;
  localparam int unsigned STEP   = 1 << WORD_SH;

  logic [XLEN-1:0] imm_sext;
  logic [XLEN-1:0] word_off;
  logic [XLEN-1:0] hi_off;
  logic [HI_W-1:0] hi_raw;

  always_comb begin
    imm_sext = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
    word_off = imm_sext << WORD_SH;
    hi_raw   = {imm, {HI_SH{1'b0}}};
  end

  generate
    if (XLEN > HI_W) begin : g_hi_pad
      assign hi_off = {{(XLEN-HI_W){1'b0}}, hi_raw};
    end else begin : g_hi_trunc
      assign hi_off = hi_raw[XLEN-1:0];
    end
  endgenerate

  always_comb begin
    br_target  = pc + word_off;
    jmp_target = src + word_off;
    seq_pc     = pc + XLEN'(STEP);
    hi_sum     = pc + hi_off;
  end
endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit
  import bru_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IMM_W = 21
) (
  input  logic [XLEN-1:0]  pc_i,
  input  logic [XLEN-1:0]  src_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [OP_W-1:0]  op_i,
  output logic             taken_o,
  output logic [XLEN-1:0]  next_pc_o,
  output logic             link_we_o,
  output logic [XLEN-1:0]  link_value_o,
  output logic [XLEN-1:0]  pchi_result_o
);
  bru_class_t      cls;
  logic            cond_true;
  logic [XLEN-1:0] br_target;
  logic [XLEN-1:0] jmp_target;
  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] hi_sum;

  bru_decode u_decode (
    .op  (op_i),
    .cls (cls)
  );

  bru_cond_eval #(.XLEN(XLEN)) u_cond (
    .src       (src_i),
    .op        (op_i),
    .cond_true (cond_true)
  );

  bru_target_gen #(.XLEN(XLEN), .IMM_W(IMM_W)) u_tgt (
    .pc         (pc_i),
    .src        (src_i),
    .imm        (imm_i),
    .br_target  (br_target),
    .jmp_target (jmp_target),
    .seq_pc     (seq_pc),
    .hi_sum     (hi_sum)
  );

  always_comb begin
    taken_o   = cls.is_jump | (cls.is_cond & cond_true);
    next_pc_o = seq_pc;
    if (cls.is_jump)
      next_pc_o = jmp_target;
    else if (cls.is_cond && cond_true)
      next_pc_o = br_target;
    link_we_o     = cls.is_link;
    link_value_o  = seq_pc;
    pchi_result_o = hi_sum;
  end
endmodule

// File: rtl/branch_resolve_unit_chk.sv
module branch_resolve_unit_chk #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IMM_W = 21
) (
  input logic [XLEN-1:0]  pc_i,
  input logic [XLEN-1:0]  src_i,
  input logic [IMM_W-1:0] imm_i,
  input logic [3:0]       op_i,
  input logic             taken_o,
  input logic [XLEN-1:0]  next_pc_o,
  input logic             link_we_o,
  input logic [XLEN-1:0]  link_value_o,
  input logic [XLEN-1:0]  pchi_result_o
);
  always_comb begin
    if (!$isunknown(op_i)) begin
      assert_link_only_jl_R3: assert (!link_we_o || op_i == 4'd1)
        else $error("link enable outside jump-and-link");
      assert_link_addr_R3: assert (!link_we_o || link_value_o == pc_i + 32'd4)
        else $error("link value not pc+4");
      assert_jump_taken_R2: assert (!(op_i == 4'd0 || op_i == 4'd1) || taken_o)
        else $error("jump not taken");
      assert_seq_pc_R8: assert (taken_o || next_pc_o == pc_i + 32'd4)
        else $error("not-taken next pc wrong");
      assert_pchi_quiet_R9: assert (op_i != 4'd10 || (!taken_o && !link_we_o))
        else $error("pc-high-add changed control flow");
      assert_unknown_op_R10: assert (op_i < 4'd11 || (!taken_o && !link_we_o))
        else $error("unrecognized opcode acted");
    end
  end
endmodule

bind branch_resolve_unit branch_resolve_unit_chk #(.XLEN(XLEN), .IMM_W(IMM_W)) u_chk (.*);

// File: tb/branch_resolve_unit_bench.sv
module branch_resolve_unit_bench;
  logic        clk;
  logic        rst_n;
  logic [31:0] pc, src;
  logic [20:0] imm;
  logic [3:0]  op;
  logic        taken, link_we;
  logic [31:0] next_pc, link_value, pchi;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  branch_resolve_unit u_branch_resolve_unit (
    .pc_i(pc), .src_i(src), .imm_i(imm), .op_i(op),
    .taken_o(taken), .next_pc_o(next_pc), .link_we_o(link_we),
    .link_value_o(link_value), .pchi_result_o(pchi)
  );

  function automatic logic [31:0] sx4(input logic [20:0] i);
    return {{11{i[20]}}, i} * 32'd4;
  endfunction

  function automatic bit cond_model(input logic [3:0] o, input logic [31:0] s);
    int signed v;
    v = signed'(s);
    case (o)
      4'd2: return v == 0;
      4'd3: return v != 0;
      4'd4: return s == 32'hFFFF_FFFF;
      4'd5: return s != 32'hFFFF_FFFF;
      4'd6: return v < 0;
      4'd7: return v >= 0;
      4'd8: return v <= 0;
      4'd9: return v > 0;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h (op=%0d pc=%h src=%h imm=%h)",
               req, got, exp, op, pc, src, imm);
    end
  endtask

  task automatic apply(input logic [3:0] o, input logic [31:0] p,
                       input logic [31:0] s, input logic [20:0] i);
    @(negedge clk);
    op = o; pc = p; src = s; imm = i;
    @(posedge clk);
    #1;
  endtask

  task automatic test_reset_state;
    apply(4'd15, 32'h0, 32'h0, 21'h0);
    chk("R10 idle taken", {31'd0, taken}, 32'd0);
    chk("R10 idle next", next_pc, 32'd4);
    chk("R10 idle link_we", {31'd0, link_we}, 32'd0);
  endtask

  task automatic test_conditions;
    logic [31:0] vals [7];
    vals = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF, 32'hFFFF_FFFE, 32'h55AA_0000};
    for (int o = 2; o <= 9; o++) begin
      for (int k = 0; k < 7; k++) begin
        bit t;
        apply(4'(o), 32'h0000_1000, vals[k], 21'h00010);
        t = cond_model(4'(o), vals[k]);
        if (o <= 3)      chk("R4 cond", {31'd0, taken}, {31'd0, t});
        else if (o <= 5) chk("R5 cond", {31'd0, taken}, {31'd0, t});
        else if (o <= 7) chk("R6 cond", {31'd0, taken}, {31'd0, t});
        else             chk("R7 cond", {31'd0, taken}, {31'd0, t});
        if (t) chk("R1 target", next_pc, 32'h0000_1000 + sx4(21'h00010));
        else   chk("R8 fallthrough", next_pc, 32'h0000_1004);
        chk("R3 no link on branch", {31'd0, link_we}, 32'd0);
      end
    end
  endtask

  task automatic test_branch_wrap;
    apply(4'd2, 32'h0000_0008, 32'h0, 21'h1FFFFD);
    chk("R1 negative offset wrap", next_pc, 32'hFFFF_FFFC);
    apply(4'd3, 32'hFFFF_FFFC, 32'h5, 21'h000002);
    chk("R1 positive offset wrap", next_pc, 32'h0000_0004);
    apply(4'd9, 32'hFFFF_FFFC, 32'h0, 21'h000002);
    chk("R8 pc+4 wrap", next_pc, 32'h0000_0000);
  endtask

  task automatic test_jumps;
    apply(4'd0, 32'h0000_2000, 32'h0040_0000, 21'h100000);
    chk("R2 jump taken", {31'd0, taken}, 32'd1);
    chk("R2 jump target", next_pc, 32'h0040_0000 + sx4(21'h100000));
    chk("R3 plain jump no link", {31'd0, link_we}, 32'd0);
    apply(4'd1, 32'h0000_3000, 32'h0000_3000, 21'h0FFFFF);
    chk("R2 jl taken", {31'd0, taken}, 32'd1);
    chk("R2 jl target", next_pc, 32'h0000_3000 + sx4(21'h0FFFFF));
    chk("R3 jl link_we", {31'd0, link_we}, 32'd1);
    chk("R3 jl link value", link_value, 32'h0000_3004);
    apply(4'd0, 32'h0, 32'h0, 21'h0);
    chk("R2 jump zero base taken", {31'd0, taken}, 32'd1);
    chk("R2 jump zero target", next_pc, 32'h0);
  endtask

  task automatic test_pchi;
    apply(4'd10, 32'h1234_5678, 32'hFFFF_FFFF, 21'h1FFFFF);
    chk("R9 pchi value", pchi, 32'h1234_5678 + 32'hFFFF_F800);
    chk("R9 pchi not taken", {31'd0, taken}, 32'd0);
    chk("R9 pchi next", next_pc, 32'h1234_567C);
    chk("R9 pchi no link", {31'd0, link_we}, 32'd0);
    apply(4'd10, 32'h0000_0100, 32'h0, 21'h000001);
    chk("R9 pchi small", pchi, 32'h0000_0900);
    apply(4'd2, 32'h0000_0100, 32'h0, 21'h0ABCDE);
    chk("R9 pchi on other op", pchi, 32'h0000_0100 + (32'h0ABCDE << 11));
  endtask

  task automatic test_unknown_ops;
    for (int o = 11; o <= 15; o++) begin
      apply(4'(o), 32'h0000_8000, 32'h0, 21'h000100);
      chk("R10 taken", {31'd0, taken}, 32'd0);
      chk("R10 next", next_pc, 32'h0000_8004);
      chk("R10 link_we", {31'd0, link_we}, 32'd0);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    op = 4'd15; pc = '0; src = '0; imm = '0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    test_reset_state();
    test_conditions();
    test_branch_wrap();
    test_jumps();
    test_pchi();
    test_unknown_ops();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          checks++;
          errors++;
          $display("FAIL watchdog: got timeout expected completion");
        end
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule